// File: doc/BRIEF.md
# Dual-Channel High/Low-Count Pulse Generator

This block drives two pulse-width-modulated outputs from a small 32-bit register interface. Each channel has a count word made of two 16-bit fields. One field is the number of prescaled ticks the output stays high. The other is the number of ticks it then stays low. The cycle repeats for as long as the channel runs. A single control word is shared by both channels. For each channel it holds an output enable, a prescaler enable, a 7-bit divide value and a 2-bit field that picks one of four incoming clock-enable strobes.

All logic runs on one system clock. The four clock sources arrive as single-cycle enable strobes in that clock domain. The prescaler counts strobes of the chosen source and emits one tick every N+1 strobes. A new count word can be written while a channel runs. It is applied only when the current period ends, so a period never mixes old and new counts.

Top module: `pwm_hilo_pair`

## Requirements
- R1: Writes use byte offsets 0x0 (channel A counts), 0x4 (channel B counts) and 0x8 (control), decoded from `reg_addr[3:2]`. A read returns the last value written. Control bits 2, 3 and 31:24 always read as 0. Offset 0xC reads as 0.
- R2: In a count word, bits 31:16 are the high count H and bits 15:0 are the low count L. A running channel outputs H ticks high followed by L ticks low, and repeats this period.
- R3: Channel A runs only when control bit 0 (output enable) and control bit 15 (prescaler enable) are both 1. Channel B uses bit 1 and bit 23 in the same way.
- R4: Control bits 5:4 (channel A) and 7:6 (channel B) select which `clk_en_src` strobe line feeds that channel's prescaler. Strobes on any other line do not advance the channel.
- R5: Control bits 14:8 (channel A) and 22:16 (channel B) hold a divide value N. One tick occurs for every N+1 selected strobes. With the strobe held high, one tick occurs every N+1 cycles.
- R6: If H=0 and L>0, the output stays low. If L=0 and H>0, the output stays high. If H=0 and L=0, the output stays low.
- R7: While a channel is not running, its output is 0 and its prescaler and phase position are cleared. In the first cycle after the write that starts the channel, the output begins a new high phase.
- R8: A count word written while the channel runs takes effect at the next period boundary.
- R9: The two channels run independently and at the same time, each using its own fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe |
| reg_addr | input | 4 | Byte address; bits 3:2 select the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| clk_en_src | input | 4 | Four clock-enable strobe sources |
| pwm_out | output | 2 | Channel outputs, bit 0 = A, bit 1 = B |

## Verification
The period generator is exercised with several configurations:
- Short and long high/low splits, which separate the high-count field from the low-count field.
- Divide values of 0 and above, which expose off-by-one errors in the prescaler.
- Every source select on both channels, driven by a strobe on only the selected line, which catches a wrong field position or a wrong strobe index.
- Zero counts, which check that the constant-level cases do not toggle.

Directed runs cover three further behaviours:
- A count write in the middle of a period, where the output sequence shows whether the reload waits for the boundary.
- Stopping and restarting a channel, which shows whether the new high phase really starts from the beginning.
- Both channels running together, which exposes any sharing of state between them.

// File: rtl/pwm_hilo_pair.sv
module pwm_hilo_pair #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [3:0]  clk_en_src,
  output logic [1:0]  pwm_out
);
  localparam logic [31:0] CTRL_MASK = 32'h00FF_FFF3;
  localparam int POS_W = CNT_W + 1;

  logic [31:0] cnt_word [2];
  logic [31:0] ctrl_q;

  logic [1:0]                   run, tick, wrap;
  logic [1:0][1:0]              src_sel;
  logic [1:0][DIV_W-1:0]        div, psc;
  logic [1:0][CNT_W-1:0]        act_hi, act_lo;
  logic [1:0][POS_W-1:0]        pos, total;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_word[0] <= '0;
      cnt_word[1] <= '0;
      ctrl_q      <= '0;
    end else if (reg_we) begin
      case (reg_addr[3:2])
        2'd0: cnt_word[0] <= reg_wdata;
        2'd1: cnt_word[1] <= reg_wdata;
        2'd2: ctrl_q      <= reg_wdata & CTRL_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr[3:2])
      2'd0:    reg_rdata = cnt_word[0];
      2'd1:    reg_rdata = cnt_word[1];
      2'd2:    reg_rdata = ctrl_q;
      default: reg_rdata = '0;
    endcase
  end

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      run[c]     = ctrl_q[c] & ctrl_q[15 + 8*c];
      src_sel[c] = ctrl_q[4 + 2*c +: 2];
      div[c]     = ctrl_q[8 + 8*c +: DIV_W];
      tick[c]    = run[c] & clk_en_src[src_sel[c]] & (psc[c] == div[c]);
      total[c]   = {1'b0, act_hi[c]} + {1'b0, act_lo[c]};
      wrap[c]    = (pos[c] + POS_W'(1)) >= total[c];
      pwm_out[c] = run[c] & (pos[c] < {1'b0, act_hi[c]});
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (!rst_n) begin
        psc[c]    <= '0;
        pos[c]    <= '0;
        act_hi[c] <= '0;
        act_lo[c] <= '0;
      end else if (!run[c]) begin
        psc[c]    <= '0;
        pos[c]    <= '0;
        act_hi[c] <= cnt_word[c][31:16];
        act_lo[c] <= cnt_word[c][CNT_W-1:0];
      end else begin
        if (clk_en_src[src_sel[c]])
          psc[c] <= (psc[c] == div[c]) ? '0 : psc[c] + DIV_W'(1);
        if (tick[c]) begin
          if (wrap[c]) begin
            pos[c]    <= '0;
            act_hi[c] <= cnt_word[c][31:16];
            act_lo[c] <= cnt_word[c][CNT_W-1:0];
          end else begin
            pos[c] <= pos[c] + POS_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/pwm_hilo_pair_chk.sv
module pwm_hilo_pair_chk #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 7
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [3:0]                 reg_addr,
  input logic [31:0]                reg_rdata,
  input logic [1:0]                 pwm_out,
  input logic [1:0]                 run,
  input logic [1:0]                 tick,
  input logic [1:0][DIV_W-1:0]      div,
  input logic [1:0][DIV_W-1:0]      psc,
  input logic [1:0][CNT_W-1:0]      act_hi,
  input logic [1:0][CNT_W-1:0]      act_lo,
  input logic [1:0][CNT_W:0]        pos,
  input logic [1:0][CNT_W:0]        total
);
  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr[3:2] == 2'd2 |-> (reg_rdata[31:24] == 8'd0 && reg_rdata[3:2] == 2'd0)); // R1

  for (genvar c = 0; c < 2; c++) begin : g_chk
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run[c] |-> !pwm_out[c]); // R7
    AST_PSC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run[c] |-> psc[c] <= div[c]); // R5
    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (run[c] && total[c] != '0) |-> pos[c] < total[c]); // R2
    AST_RELOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      (run[c] && !tick[c]) |=> (!run[c] || ($stable(act_hi[c]) && $stable(act_lo[c])))); // R8
    AST_CONST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (run[c] && act_lo[c] == '0 && act_hi[c] != '0) |-> pwm_out[c]); // R6
  end
endmodule

bind pwm_hilo_pair pwm_hilo_pair_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .pwm_out(pwm_out), .run(run), .tick(tick), .div(div), .psc(psc),
  .act_hi(act_hi), .act_lo(act_lo), .pos(pos), .total(total)
);

// File: tb/test_pwm_hilo_pair.sv
module test_pwm_hilo_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  clk_en_src = '0;
  logic [1:0]  pwm_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_hilo_pair i_pwm_hilo_pair (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .clk_en_src(clk_en_src), .pwm_out(pwm_out)
  );

  // channel, high, low, divide, source
  localparam int NV = 9;
  localparam int VEC [NV][5] = '{
    '{0, 3, 2, 0, 0},
    '{0, 1, 1, 0, 1},
    '{0, 4, 0, 0, 2},
    '{0, 0, 3, 0, 3},
    '{0, 2, 3, 2, 0},
    '{1, 2, 2, 0, 1},
    '{1, 1, 3, 3, 2},
    '{1, 0, 0, 0, 0},
    '{1, 5, 1, 1, 3}
  };

  function automatic logic [31:0] mk_ctrl(int ch, int sel, int dv, bit oen, bit pen);
    logic [31:0] v = '0;
    v[ch] = oen;
    v[4 + 2*ch +: 2] = 2'(sel);
    v[8 + 8*ch +: 7] = 7'(dv);
    v[15 + 8*ch] = pen;
    return v;
  endfunction

  function automatic bit model(int k, int hi, int lo, int dv);
    if (hi + lo == 0) return 1'b0;
    return ((k / (dv + 1)) % (hi + lo)) < hi;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic seq_check(input string req, input int ch, input logic [15:0] exp_bits, input int n);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      if (pwm_out[ch] !== exp_bits[k]) bad++;
      @(negedge clk);
    end
    check(req, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R7 reset out", pwm_out, 0);
    rd_check("R1 reset A", 4'h0, 0);
    rd_check("R1 reset B", 4'h4, 0);
    rd_check("R1 reset ctrl", 4'h8, 0);

    // R1 readback
    wr(4'h0, 32'hDEAD_BEEF);
    wr(4'h4, 32'h1234_5678);
    wr(4'h8, 32'hFFFF_FFFF);
    rd_check("R1 read A", 4'h0, 32'hDEAD_BEEF);
    rd_check("R1 read B", 4'h4, 32'h1234_5678);
    rd_check("R1 read ctrl masked", 4'h8, 32'h00FF_FFF3);
    rd_check("R1 read unmapped", 4'hC, 0);
    wr(4'h8, 0);

    // vector table: R2 R3 R4 R5 R6 R9
    for (int v = 0; v < NV; v++) begin
      int ch = VEC[v][0];
      int hi = VEC[v][1];
      int lo = VEC[v][2];
      int dv = VEC[v][3];
      int sl = VEC[v][4];
      int n = 2 * (hi + lo) * (dv + 1) + 4;
      int bad = 0;
      if (n < 12) n = 12;
      wr(4'h8, 0);
      clk_en_src = 4'(1 << sl);
      wr(4'(ch * 4), {16'(hi), 16'(lo)});
      wr(4'h8, mk_ctrl(ch, sl, dv, 1'b1, 1'b1));
      for (int k = 0; k < n; k++) begin
        if (pwm_out[ch] !== model(k, hi, lo, dv) || pwm_out[1-ch] !== 1'b0) bad++;
        @(negedge clk);
      end
      check($sformatf("R2 R4 R5 R6 vector %0d mismatching cycles", v), bad, 0);
    end

    // R3: output enable without prescaler enable keeps channel idle
    wr(4'h8, 0);
    clk_en_src = 4'b0001;
    wr(4'h0, {16'd2, 16'd2});
    wr(4'h8, mk_ctrl(0, 0, 0, 1'b1, 1'b0));
    seq_check("R3 out enable only stays low", 0, 16'h0000, 6);
    wr(4'h8, mk_ctrl(0, 0, 0, 1'b0, 1'b1));
    seq_check("R3 prescaler enable only stays low", 0, 16'h0000, 6);

    // R4: strobes only on unselected line -> no progress, stays high
    wr(4'h8, 0);
    clk_en_src = 4'b1000;
    wr(4'h0, {16'd1, 16'd1});
    wr(4'h8, mk_ctrl(0, 0, 0, 1'b1, 1'b1));
    seq_check("R4 unselected source ignored", 0, 16'hFFFF, 10);

    // R7: stop mid-period, then restart with a fresh high phase
    wr(4'h8, 0);
    clk_en_src = 4'b0001;
    wr(4'h0, {16'd2, 16'd2});
    wr(4'h8, mk_ctrl(0, 0, 0, 1'b1, 1'b1));
    repeat (3) @(negedge clk);
    check("R7 running low phase", pwm_out[0], 0);
    wr(4'h8, mk_ctrl(0, 0, 0, 1'b1, 1'b0));
    seq_check("R7 stopped low", 0, 16'h0000, 5);
    wr(4'h8, mk_ctrl(0, 0, 0, 1'b1, 1'b1));
    seq_check("R7 restart fresh high", 0, 16'b0011_0011, 8);

    // R8: mid-period count write applies at boundary
    wr(4'h8, 0);
    wr(4'h0, {16'd3, 16'd3});
    wr(4'h8, mk_ctrl(0, 0, 0, 1'b1, 1'b1));
    check("R8 k0 high", pwm_out[0], 1);
    @(negedge clk);
    check("R8 k1 high", pwm_out[0], 1);
    wr(4'h0, {16'd1, 16'd2});
    seq_check("R8 boundary reload", 0, 16'b1001_0001, 8);

    // R9: both channels together
    wr(4'h8, 0);
    clk_en_src = 4'b0011;
    wr(4'h0, {16'd1, 16'd1});
    wr(4'h4, {16'd2, 16'd1});
    wr(4'h8, mk_ctrl(0, 0, 0, 1'b1, 1'b1) | mk_ctrl(1, 1, 0, 1'b1, 1'b1));
    begin
      int bad = 0;
      for (int k = 0; k < 12; k++) begin
        if (pwm_out[0] !== model(k, 1, 1, 0) || pwm_out[1] !== model(k, 2, 1, 0)) bad++;
        @(negedge clk);
      end
      check("R9 independent channels", bad, 0);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule